// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of a single SDRAM read or write burst. A start strobe captures a start column together with the mode fields for burst length, burst ordering and single-location writes. From the next cycle on, the block presents one column per enabled clock, with a valid flag and a flag that marks the final beat. A memory controller or a memory model uses this sequence to step through a row during a burst.

The ordering either wraps an incrementing offset inside the aligned block that holds the start column, or XORs the start offset with a beat count. In row-length (full-page) mode the column counts through the whole row and keeps going until it is ended. A burst-stop input or a fresh start ends a burst on any cycle. While the clock enable is low, the block freezes and ignores its command inputs. A start issued while a reserved mode is programmed raises an error flag and starts no burst.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, col_valid, col_last and mode_err are 0.
- R2: cfg_len encodes the burst length as 000 = 1 beat, 001 = 2, 010 = 4 and 011 = 8. col_valid stays high for exactly that many enabled cycles. col_last is high only on the final beat, and col_valid drops on the enabled cycle after it.
- R3: When cfg_ilv = 0 (sequential ordering), the beat-i column is the aligned block base plus ((start offset + i) mod BL). The block base is the start column with its low log2(BL) bits cleared, so the upper column bits never change during a burst.
- R4: When cfg_ilv = 1 (interleaved ordering), the beat-i column is the block base plus (start offset XOR i).
- R5: cfg_len = 111 with cfg_ilv = 0 selects row mode. The column runs start, start+1, ... modulo 2^COL_W, wraps past the last column, never raises col_last, and keeps going until a stop or a new start.
- R6: When cfg_wr_single = 1, a start with burst_wr = 1 produces a single beat with col_last high, whatever the programmed length. A start with burst_wr = 0 still uses the programmed length.
- R7: A burst_stop sampled on an enabled edge without burst_start ends the burst. col_valid is 0 from that edge on, and the column shown before the edge is the last beat delivered.
- R8: A burst_start during an active burst abandons the old sequence and begins the new one on the next cycle. burst_start takes priority over a simultaneous burst_stop.
- R9: While cke is low at an edge, col_out, col_valid, col_last and mode_err keep their values, and burst_start and burst_stop have no effect.
- R10: cfg_len values 100, 101 and 110, and 111 together with cfg_ilv = 1, are reserved. An enabled start under a reserved mode sets mode_err for one enabled cycle, ends any active burst, and starts no burst.
- R11: The first column equals start_col and appears on the cycle after the enabled edge that samples burst_start. Each later enabled edge advances one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low freezes all state |
| burst_start | input | 1 | Start a burst from start_col |
| burst_wr | input | 1 | 1 = write burst, 0 = read burst |
| burst_stop | input | 1 | End the active burst |
| start_col | input | COL_W (8) | Starting column |
| cfg_len | input | 3 | Burst length code |
| cfg_ilv | input | 1 | 0 = sequential, 1 = interleaved |
| cfg_wr_single | input | 1 | Writes limited to one beat |
| col_out | output | COL_W (8) | Current column |
| col_valid | output | 1 | col_out holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Start was issued under a reserved mode |

## Verification
The assertions assume that reset is held for at least one clock before it is released. They treat command inputs as meaningful only on edges where cke is high, and they assume that start_col and the mode fields are stable at the edge that samples burst_start. The stimulus changes every input on falling clock edges only, so each value is settled before the next rising edge. The outputs are registered, so the bench samples them on the falling edge that follows each change. A bench-side flag records whether cke was high at the preceding rising edge. On frozen cycles, the scoreboard therefore compares against the previous column instead of consuming an expected beat.

// File: rtl/scbg_pkg.sv
package scbg_pkg;

    localparam int LEN_CODE_W = 3;

    typedef logic [LEN_CODE_W-1:0] len_code_t;

    // Length codes that a neighbouring mode register decodes
    localparam len_code_t LEN_ONE   = 3'b000;
    localparam len_code_t LEN_TWO   = 3'b001;
    localparam len_code_t LEN_FOUR  = 3'b010;
    localparam len_code_t LEN_EIGHT = 3'b011;
    localparam len_code_t LEN_ROW   = 3'b111;

    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_XOR = 1'b1
    } order_e;

    typedef struct packed {
        len_code_t len;
        order_e    order;
        logic      wr_single;
    } mode_cfg_t;

    typedef struct packed {
        logic       reserved;
        logic       row_mode;
        logic [1:0] len_log2;
    } len_info_t;

    // Turns the programmed mode into a length exponent, a row flag and a
    // reserved flag. A single-location write overrides the programmed length.
    function automatic len_info_t decode_len(mode_cfg_t cfg, logic is_wr);
        len_info_t r;
        r = '0;
        case (cfg.len)
            LEN_ONE:   r.len_log2 = 2'd0;
            LEN_TWO:   r.len_log2 = 2'd1;
            LEN_FOUR:  r.len_log2 = 2'd2;
            LEN_EIGHT: r.len_log2 = 2'd3;
            LEN_ROW: begin
                r.row_mode = 1'b1;
                r.reserved = (cfg.order == ORDER_XOR);
            end
            default:   r.reserved = 1'b1;
        endcase
        if (cfg.wr_single && is_wr) begin
            r.row_mode = 1'b0;
            r.len_log2 = 2'd0;
        end
        return r;
    endfunction

endpackage

// File: rtl/scbg_mode_decode.sv
module scbg_mode_decode
    import scbg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  mode_cfg_t        cfg,
    input  logic             is_wr,
    output logic             reserved,
    output logic             row_mode,
    output logic [COL_W-1:0] mask
);

    localparam int FIXED_BITS = 3;  // widest fixed-length burst is 2**3

    len_info_t info;

    assign info     = decode_len(cfg, is_wr);
    assign reserved = info.reserved;
    assign row_mode = info.row_mode;

    // Bits that change during a burst: the low log2(BL) bits, or all in row mode
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        if (i < FIXED_BITS) begin : g_low
            assign mask[i] = info.row_mode | (info.len_log2 > 2'(i));
        end else begin : g_high
            assign mask[i] = info.row_mode;
        end
    end

endmodule

// File: rtl/scbg_beat_ctr.sv
module scbg_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic             kill,
    input  logic             row_mode,
    input  logic [COL_W-1:0] last_idx,
    output logic [COL_W-1:0] beat,
    output logic             active,
    output logic             last_beat
);

    logic at_end;

    assign at_end    = !row_mode && (beat == last_idx);
    assign last_beat = active && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (en) begin
            if (load) begin
                active <= 1'b1;
                beat   <= '0;
            end else if (kill) begin
                active <= 1'b0;
            end else if (active) begin
                if (at_end) begin
                    active <= 1'b0;
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

    AST_BEAT_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (active && !row_mode) |-> ((beat & ~last_idx) == '0)); // R2

endmodule

// File: rtl/scbg_addr_map.sv
module scbg_addr_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] mask,
    input  logic             order_xor,
    input  logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] inc_low;
    logic [COL_W-1:0] xor_low;

    // Carries out of the changing field are dropped by the mask below
    assign inc_low = base + beat;
    assign xor_low = base ^ beat;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask[i] ? (order_xor ? xor_low[i] : inc_low[i]) : base[i];
    end

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
    import scbg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             burst_start,
    input  logic             burst_wr,
    input  logic             burst_stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       cfg_len,
    input  logic             cfg_ilv,
    input  logic             cfg_wr_single,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last,
    output logic             mode_err
);

    mode_cfg_t        cfg;
    logic             rsv;
    logic             row_d;
    logic [COL_W-1:0] mask_d;
    logic             load;
    logic             kill;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             row_q;
    logic             order_q;
    logic             err_q;
    logic [COL_W-1:0] beat;

    assign cfg.len       = cfg_len;
    assign cfg.order     = order_e'(cfg_ilv);
    assign cfg.wr_single = cfg_wr_single;

    scbg_mode_decode #(.COL_W(COL_W)) mode_dec_i (
        .cfg      (cfg),
        .is_wr    (burst_wr),
        .reserved (rsv),
        .row_mode (row_d),
        .mask     (mask_d)
    );

    // A start always wins over a stop; a start under a reserved mode only ends
    assign load = burst_start && !rsv;
    assign kill = (burst_start && rsv) || burst_stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            mask_q  <= '0;
            row_q   <= 1'b0;
            order_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (cke) begin
            err_q <= burst_start && rsv;
            if (load) begin
                base_q  <= start_col;
                mask_q  <= mask_d;
                row_q   <= row_d;
                order_q <= cfg_ilv;
            end
        end
    end

    scbg_beat_ctr #(.COL_W(COL_W)) beat_ctr_i (
        .clk       (clk),
        .rst       (rst),
        .en        (cke),
        .load      (load),
        .kill      (kill),
        .row_mode  (row_q),
        .last_idx  (mask_q),
        .beat      (beat),
        .active    (col_valid),
        .last_beat (col_last)
    );

    scbg_addr_map #(.COL_W(COL_W)) addr_map_i (
        .base      (base_q),
        .mask      (mask_q),
        .order_xor (order_q),
        .beat      (beat),
        .col       (col_out)
    );

    assign mode_err = err_q;

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid); // R2

    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
        (cke && col_last && !burst_start) |=> !col_valid); // R2

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && col_valid && $past(col_valid) && $past(cke) && !$past(burst_start))
        |-> (((col_out ^ $past(col_out)) & ~mask_q) == '0)); // R3

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cke && burst_start && burst_wr && cfg_wr_single && !rsv) |=> (col_valid && col_last)); // R6

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (cke && burst_stop && !burst_start) |=> !col_valid); // R7

    AST_HOLD_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cke)) |-> ($stable(col_out) && $stable(col_valid)
                                          && $stable(col_last) && $stable(mode_err))); // R9

    AST_RESERVED_NO_BURST: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> !col_valid); // R10

    AST_FIRST_COL: assert property (@(posedge clk) disable iff (rst)
        (cke && burst_start && !rsv) |=> (col_valid && col_out == $past(start_col))); // R11

endmodule

// File: tb/sdram_col_burst_gen_tb_top.sv
module sdram_col_burst_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       burst_start = 1'b0;
    logic       burst_wr = 1'b0;
    logic       burst_stop = 1'b0;
    logic [7:0] start_col = 8'h00;
    logic [2:0] cfg_len = 3'b000;
    logic       cfg_ilv = 1'b0;
    logic       cfg_wr_single = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       col_last;
    logic       mode_err;

    always #10 clk = ~clk;  // 50 MHz

    sdram_col_burst_gen #(.COL_W(8)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .cke           (cke),
        .burst_start   (burst_start),
        .burst_wr      (burst_wr),
        .burst_stop    (burst_stop),
        .start_col     (start_col),
        .cfg_len       (cfg_len),
        .cfg_ilv       (cfg_ilv),
        .cfg_wr_single (cfg_wr_single),
        .col_out       (col_out),
        .col_valid     (col_valid),
        .col_last      (col_last),
        .mode_err      (mode_err)
    );

    typedef struct {
        logic [7:0] col;
        logic       last;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    int         checks = 0;
    int         errors = 0;
    logic       fresh = 1'b0;
    logic [7:0] prev_col = 8'h00;
    bit         done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // fresh = outputs may have moved at the last rising edge
    always @(posedge clk) fresh <= cke;

    // Monitor: pops one expected beat per newly presented column
    always @(negedge clk) begin
        exp_t e;
        if (!rst && col_valid) begin
            if (!fresh) begin
                check(col_out == prev_col, "R9", "held column", col_out, prev_col);
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected beat", col_out, 0);
            end else begin
                e = exp_q.pop_front();
                check(col_out == e.col, e.req, "column", col_out, e.col);
                check(col_last == e.last, e.req, "last flag", col_last, e.last);
                prev_col = col_out;
            end
        end
    end

    function automatic logic [7:0] model_col(logic [7:0] s, int bl, bit ilv, int i);
        int off  = s % bl;
        int base = s - off;
        if (ilv) return 8'(base + (off ^ i));
        return 8'(base + ((off + i) % bl));
    endfunction

    task automatic push_beats(input logic [7:0] s, input int bl, input bit ilv,
                              input int count, input bit natural, input string req);
        for (int i = 0; i < count; i++) begin
            exp_t e;
            e.col  = model_col(s, bl, ilv, i);
            e.last = natural && (i == count - 1);
            e.req  = req;
            exp_q.push_back(e);
        end
    endtask

    // Caller stands at a falling edge; returns one falling edge later
    task automatic issue(input logic [7:0] s, input logic [2:0] len, input bit ilv,
                         input bit single, input bit wr, input bit stp);
        start_col     = s;
        cfg_len       = len;
        cfg_ilv       = ilv;
        cfg_wr_single = single;
        burst_wr      = wr;
        burst_start   = 1'b1;
        burst_stop    = stp;
        @(negedge clk);
        burst_start = 1'b0;
        burst_stop  = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input int n, input string req);
        wait_n(n);
        check(exp_q.size() == 0, req, "beats still owed", exp_q.size(), 0);
        check(col_valid == 1'b0, req, "valid after burst", col_valid, 0);
    endtask

    task automatic stop_after(input int j, input string req);
        wait_n(j);
        burst_stop = 1'b1;
        wait_n(1);
        burst_stop = 1'b0;
        check(exp_q.size() == 0, req, "beats still owed", exp_q.size(), 0);
        check(col_valid == 1'b0, req, "valid after stop", col_valid, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        check(col_valid == 1'b0, "R1", "valid in reset", col_valid, 0);
        check(col_last == 1'b0, "R1", "last in reset", col_last, 0);
        check(mode_err == 1'b0, "R1", "err in reset", mode_err, 0);
        rst = 1'b0;
        wait_n(1);
        check(col_valid == 1'b0 && mode_err == 1'b0, "R1", "idle after reset", col_valid, 0);

        // R2: each fixed length, sequential from 0x5B
        for (int code = 0; code < 4; code++) begin
            push_beats(8'h5B, 1 << code, 1'b0, 1 << code, 1'b1, "R2");
            issue(8'h5B, 3'(code), 1'b0, 1'b0, 1'b0, 1'b0);
            drain(1 << code, "R2");
        end

        // R3: sequential wrap inside the aligned block
        push_beats(8'hA5, 8, 1'b0, 8, 1'b1, "R3");
        issue(8'hA5, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0);
        drain(8, "R3");
        push_beats(8'h3E, 4, 1'b0, 4, 1'b1, "R3");
        issue(8'h3E, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0);
        drain(4, "R3");

        // R4: interleaved ordering
        push_beats(8'h05, 8, 1'b1, 8, 1'b1, "R4");
        issue(8'h05, 3'b011, 1'b1, 1'b0, 1'b0, 1'b0);
        drain(8, "R4");
        push_beats(8'h9A, 4, 1'b1, 4, 1'b1, "R4");
        issue(8'h9A, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0);
        drain(4, "R4");
        push_beats(8'h11, 2, 1'b1, 2, 1'b1, "R4");
        issue(8'h11, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0);
        drain(2, "R4");

        // R11: first beat is start_col, one beat per cycle
        push_beats(8'hC1, 2, 1'b0, 2, 1'b1, "R11");
        issue(8'hC1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0);
        drain(2, "R11");

        // R5: row mode runs past the end of the row, no last flag
        push_beats(8'hFD, 256, 1'b0, 260, 1'b0, "R5");
        issue(8'hFD, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
        stop_after(259, "R5");

        // R6: single-location writes; reads keep programmed length
        push_beats(8'h27, 8, 1'b0, 1, 1'b1, "R6");
        issue(8'h27, 3'b011, 1'b0, 1'b1, 1'b1, 1'b0);
        drain(1, "R6");
        push_beats(8'h27, 8, 1'b0, 8, 1'b1, "R6");
        issue(8'h27, 3'b011, 1'b0, 1'b1, 1'b0, 1'b0);
        drain(8, "R6");
        push_beats(8'h64, 1, 1'b0, 1, 1'b1, "R6");
        issue(8'h64, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0);
        drain(1, "R6");

        // R7: stop mid-burst and on the first beat
        push_beats(8'h20, 8, 1'b0, 3, 1'b0, "R7");
        issue(8'h20, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0);
        stop_after(2, "R7");
        push_beats(8'h4C, 4, 1'b1, 1, 1'b0, "R7");
        issue(8'h4C, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0);
        stop_after(0, "R7");

        // R8: restart mid-burst with a simultaneous stop
        push_beats(8'h10, 8, 1'b0, 3, 1'b0, "R8");
        issue(8'h10, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_n(2);
        push_beats(8'h33, 4, 1'b0, 4, 1'b1, "R8");
        issue(8'h33, 3'b010, 1'b0, 1'b0, 1'b0, 1'b1);
        drain(4, "R8");

        // R9: freeze mid-burst; stop during the freeze is ignored
        push_beats(8'h42, 4, 1'b0, 4, 1'b1, "R9");
        issue(8'h42, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0);
        cke = 1'b0;
        burst_stop = 1'b1;
        wait_n(1);
        cke = 1'b1;
        burst_stop = 1'b0;
        drain(4, "R9");
        // R9: start while frozen is ignored
        cke = 1'b0;
        start_col = 8'h07;
        cfg_len = 3'b001;
        burst_start = 1'b1;
        wait_n(1);
        burst_start = 1'b0;
        cke = 1'b1;
        wait_n(2);
        check(col_valid == 1'b0, "R9", "frozen start ignored", col_valid, 0);
        check(mode_err == 1'b0, "R9", "err after frozen start", mode_err, 0);

        // R10: reserved length codes and row mode with interleave
        issue(8'h00, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0);
        check(mode_err == 1'b1, "R10", "err on code 101", mode_err, 1);
        check(col_valid == 1'b0, "R10", "no burst on 101", col_valid, 0);
        wait_n(1);
        check(mode_err == 1'b0, "R10", "err clears", mode_err, 0);
        issue(8'h80, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0);
        check(mode_err == 1'b1, "R10", "err on row+ilv", mode_err, 1);
        check(col_valid == 1'b0, "R10", "no burst on row+ilv", col_valid, 0);
        wait_n(1);
        // R10: reserved start ends an active burst
        push_beats(8'h00, 8, 1'b0, 2, 1'b0, "R10");
        issue(8'h00, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_n(1);
        issue(8'h00, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0);
        check(mode_err == 1'b1, "R10", "err on code 110", mode_err, 1);
        check(col_valid == 1'b0, "R10", "burst ended by reserved start", col_valid, 0);
        check(exp_q.size() == 0, "R10", "beats still owed", exp_q.size(), 0);
        wait_n(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule